// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block sits on the host side of a three-wire serial EEPROM link that holds 16-bit words. It drives chip select, the serial clock and the data line toward the memory, and it samples the memory's data return line. The system side is a one-cycle request: an opcode, a word address, write data and a word count for sequential reads. Read words come back one at a time with a strobe. A `done` pulse and a `busy` level frame each transaction.

The serial clock comes from the system clock. Its high and low phases have parameterised lengths. Chip select always returns low for a minimum number of cycles between two high periods. After a command that programs the array, the controller raises chip select again with the data line low and the clock idle, then watches the return line. A low level means the memory is still programming and a high level means it is ready. Chip select drops in the cycle after ready is seen. If ready never comes, a cycle counter ends the wait and sets an error flag.

Top module: `mw_host`

## Requirements
- R1: A request is taken only when `busy` is low and `req_op` is not 7. `busy` rises on the next cycle. A `req_valid` pulse while `busy` is high, or one with opcode 7, starts no transaction.
- R2: A frame begins with an address field preceded by a start bit of 1 and a two-bit command code, all sent MSB first. The address field is 8 bits. For single-word commands it holds 0 followed by the 7-bit address. The request opcodes and their command code / address-field pairs are: 0 read = 10/{0,addr}; 1 write = 01/{0,addr}; 2 erase = 11/{0,addr}; 3 write-enable = 00/11000000; 4 write-disable = 00/00000000; 5 write-all = 00/01000000; 6 erase-all = 00/10000000.
- R3: `ee_di` does not change while `ee_sk` is high, so it is steady at every rising edge. Each clock high phase lasts exactly THIGH cycles. Each low phase before a rising edge lasts at least TLOW cycles. `ee_sk` is never high while `ee_cs` is low.
- R4: Write and write-all send 16 data bits MSB first after the header, for 27 clocks in total. Every other command except read sends 11 clocks.
- R5: A read sends 11 + 16·N clocks under one chip-select period, where N is `req_count` and a count of 0 means 1. The bit returned during the last address clock is dropped. N words are returned, each assembled MSB first, each with a one-cycle `rd_valid` while `busy` is high.
- R6: Once chip select has fallen, it stays low for at least TCSL cycles before it rises again.
- R7: After write, erase, write-all and erase-all, chip select rises again once the gap has passed. While it is high, the clock and data lines stay low. Chip select falls in the cycle after `ee_do` is seen high.
- R8: If `ee_do` stays low for POLL_MAX polling cycles, chip select is dropped and `err_timeout` is set. `done` still pulses. `err_timeout` holds until the next accepted request clears it.
- R9: `done` is a one-cycle pulse at the end of every transaction, in the same cycle that `busy` falls.
- R10: During and after reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `rd_valid` and `err_timeout` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request opcode (see R2) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data for write and write-all |
| req_count | input | CW | Words per read, 0 counts as 1 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | DW | Last word read |
| rd_valid | output | 1 | `rd_data` holds a new word |
| err_timeout | output | 1 | Last status poll ran out of time |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and status from the memory |

## Verification
A behavioural memory model in the bench decodes the frames, so the bench can see the consequences of each one. A wrong command code for write-disable would leave writes enabled, and a later read would then show the overwritten word. Failing to drop the dummy bit would shift every word read by one bit. The bench runs a read that wraps across the top address, and one with a count of zero, to catch a miscounted clock total. It also holds the model busy forever to confirm that the poll ends with the error flag and does not hang. Phase lengths, the chip-select gap and clock activity while polling are watched on every cycle. A controller that clocked during the poll would hand the ready level to the memory as a start bit.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_WEN   = 3'd3;
  localparam logic [2:0] OP_WDIS  = 3'd4;
  localparam logic [2:0] OP_WALL  = 3'd5;
  localparam logic [2:0] OP_EALL  = 3'd6;
  localparam logic [2:0] OP_NONE  = 3'd7;

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_HIGH, S_GAP, S_POLL
  } seq_state_e;
endpackage

// File: rtl/mw_cycle_timer.sv
module mw_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= value;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/mw_tx_shift.sv
module mw_tx_shift #(
  parameter int FW = 27
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic          shift,
  input  logic          clear,
  output logic          bit_o
);
  logic [FW-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || clear) sr <= '0;
    else if (load)    sr <= frame;
    else if (shift)   sr <= {sr[FW-2:0], 1'b0};
  end

  assign bit_o = sr[FW-1];
endmodule

// File: rtl/mw_rx_deser.sv
module mw_rx_deser #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic          bit_i,
  output logic [DW-1:0] word_o,
  output logic          valid_o
);
  localparam int BW = $clog2(DW);

  logic [DW-1:0] sh;
  logic [BW-1:0] nbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      nbit    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap) begin
        sh <= {sh[DW-2:0], bit_i};
        if (nbit == BW'(DW - 1)) begin
          nbit    <= '0;
          word_o  <= {sh[DW-2:0], bit_i};
          valid_o <= 1'b1;
        end else begin
          nbit <= nbit + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mw_host.sv
module mw_host
  import mw_pkg::*;
#(
  parameter int AW       = 7,
  parameter int DW       = 16,
  parameter int CW       = 8,
  parameter int THIGH    = 4,
  parameter int TLOW     = 4,
  parameter int TCSL     = 8,
  parameter int POLL_MAX = 200000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] req_count,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          err_timeout,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  input  logic          ee_do
);
  localparam int HDR   = AW + 4;
  localparam int FW    = HDR + DW;
  localparam int CLKW  = $clog2(HDR + DW * (2 ** CW)) + 1;
  localparam int PMAXV = (THIGH > TLOW) ? ((THIGH > TCSL) ? THIGH : TCSL)
                                        : ((TLOW > TCSL) ? TLOW : TCSL);
  localparam int PW    = $clog2(PMAXV + 1);
  localparam int QW    = $clog2(POLL_MAX + 1);

  seq_state_e      st;
  logic            is_read, need_poll;
  logic [CLKW-1:0] clk_idx, clk_last, last_req;
  logic [HDR-1:0]  hdr;
  logic [DW-1:0]   data_part;
  logic [CW:0]     words;
  logic            accept, is_last, ph_load, ph_zero, pl_load, pl_zero;
  logic            poll_exit, cap, sh_step, sh_clr;
  logic [PW-1:0]   ph_val;

  assign accept    = (st == S_IDLE) && req_valid && (req_op != OP_NONE);
  assign is_last   = (clk_idx == clk_last);
  assign poll_exit = (st == S_POLL) && (ee_do || pl_zero);

  // frame header and length for the request on the inputs
  always_comb begin
    case (req_op)
      OP_READ:  hdr = {3'b110, 1'b0, req_addr};
      OP_WRITE: hdr = {3'b101, 1'b0, req_addr};
      OP_ERASE: hdr = {3'b111, 1'b0, req_addr};
      OP_WEN:   hdr = {3'b100, 2'b11, {(AW-1){1'b0}}};
      OP_WDIS:  hdr = {3'b100, 2'b00, {(AW-1){1'b0}}};
      OP_WALL:  hdr = {3'b100, 2'b01, {(AW-1){1'b0}}};
      OP_EALL:  hdr = {3'b100, 2'b10, {(AW-1){1'b0}}};
      default:  hdr = '0;
    endcase
    words     = (req_count == '0) ? (CW+1)'(1) : {1'b0, req_count};
    data_part = (req_op == OP_WRITE || req_op == OP_WALL) ? req_wdata : '0;
    if (req_op == OP_READ)
      last_req = CLKW'(HDR) + CLKW'(words) * CLKW'(DW) - 1'b1;
    else if (req_op == OP_WRITE || req_op == OP_WALL)
      last_req = CLKW'(FW - 1);
    else
      last_req = CLKW'(HDR - 1);
  end

  // phase length selection
  always_comb begin
    ph_load = 1'b0;
    ph_val  = '0;
    case (st)
      S_IDLE: if (accept)  begin ph_load = 1'b1; ph_val = PW'(TLOW - 1);  end
      S_LOW:  if (ph_zero) begin ph_load = 1'b1; ph_val = PW'(THIGH - 1); end
      S_HIGH: if (ph_zero) begin
        ph_load = 1'b1;
        ph_val  = is_last ? PW'(TCSL - 1) : PW'(TLOW - 1);
      end
      S_POLL: if (poll_exit) begin ph_load = 1'b1; ph_val = PW'(TCSL - 1); end
      default: ;
    endcase
  end

  assign pl_load = (st == S_GAP) && ph_zero && need_poll;
  assign cap     = (st == S_HIGH) && ph_zero && is_read && (clk_idx >= CLKW'(HDR));
  assign sh_step = (st == S_HIGH) && ph_zero && !is_last;
  assign sh_clr  = (st == S_HIGH) && ph_zero && is_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      ee_cs       <= 1'b0;
      ee_sk       <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      clk_idx     <= '0;
      clk_last    <= '0;
      is_read     <= 1'b0;
      need_poll   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st          <= S_LOW;
          ee_cs       <= 1'b1;
          busy        <= 1'b1;
          err_timeout <= 1'b0;
          clk_idx     <= '0;
          clk_last    <= last_req;
          is_read     <= (req_op == OP_READ);
          need_poll   <= (req_op == OP_WRITE) || (req_op == OP_ERASE) ||
                         (req_op == OP_WALL)  || (req_op == OP_EALL);
        end
        S_LOW: if (ph_zero) begin
          ee_sk <= 1'b1;
          st    <= S_HIGH;
        end
        S_HIGH: if (ph_zero) begin
          ee_sk <= 1'b0;
          if (is_last) begin
            ee_cs <= 1'b0;
            st    <= S_GAP;
          end else begin
            clk_idx <= clk_idx + 1'b1;
            st      <= S_LOW;
          end
        end
        S_GAP: if (ph_zero) begin
          if (need_poll) begin
            ee_cs <= 1'b1;
            st    <= S_POLL;
          end else begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_POLL: if (poll_exit) begin
          ee_cs       <= 1'b0;
          need_poll   <= 1'b0;
          err_timeout <= !ee_do;
          st          <= S_GAP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  mw_cycle_timer #(.W(PW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .value(ph_val), .zero(ph_zero)
  );

  mw_cycle_timer #(.W(QW)) u_poll (
    .clk(clk), .rst(rst), .load(pl_load), .value(QW'(POLL_MAX - 1)), .zero(pl_zero)
  );

  mw_tx_shift #(.FW(FW)) u_tx (
    .clk(clk), .rst(rst), .load(accept), .frame({hdr, data_part}),
    .shift(sh_step), .clear(sh_clr), .bit_o(ee_di)
  );

  mw_rx_deser #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .cap(cap), .bit_i(ee_do),
    .word_o(rd_data), .valid_o(rd_valid)
  );
endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk
  import mw_pkg::*;
#(
  parameter int TCSL = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       rd_valid,
  input logic       err_timeout,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic       ee_di,
  input seq_state_e st
);
  logic [15:0] low_cnt;
  logic        seen_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      seen_fall <= 1'b0;
    end else begin
      if (ee_cs)                 low_cnt <= '0;
      else if (low_cnt != '1)    low_cnt <= low_cnt + 1'b1;
      if (ee_cs)                 seen_fall <= 1'b1;
    end
  end

  a_r3_sk_needs_cs: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk);

  a_r3_di_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_sk) |-> $stable(ee_di));

  a_r6_cs_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(ee_cs) && seen_fall) |-> (low_cnt >= 16'(TCSL)));

  a_r7_poll_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == S_POLL) |-> (ee_cs && !ee_sk && !ee_di));

  a_r5_word_inside_txn: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);

  a_r8_err_inside_txn: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind mw_host mw_host_chk #(.TCSL(TCSL)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .rd_valid(rd_valid),
  .err_timeout(err_timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
  .st(st)
);

// File: tb/sim_mw_host.sv
module sim_mw_host;
  import mw_pkg::*;

  localparam int TH = 2, TL = 3, TG = 4, PMAX = 120, BUSYC = 30;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, req_valid;
  logic [2:0]  req_op;
  logic [6:0]  req_addr;
  logic [15:0] req_wdata;
  logic [7:0]  req_count;
  logic        busy, done, rd_valid, err_timeout, ee_cs, ee_sk, ee_di;
  logic        ee_do;
  logic [15:0] rd_data;

  mw_host #(.AW(7), .DW(16), .CW(8), .THIGH(TH), .TLOW(TL), .TCSL(TG),
            .POLL_MAX(PMAX)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
    .busy(busy), .done(done), .rd_data(rd_data), .rd_valid(rd_valid),
    .err_timeout(err_timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do)
  );

  int checks = 0, errors = 0;

  // memory model and line monitor state
  logic [15:0] mem [128];
  logic [15:0] rd_buf [8];
  int          rd_n = 0, done_n = 0, viol = 0;
  logic        m_started, m_rd, m_armed, m_wen, m_stuck = 1'b0;
  int          m_cnt, m_kind, m_busy, m_rb;
  logic [9:0]  m_hdr;
  logic [15:0] m_dat;
  logic [6:0]  m_a, m_ra;
  logic        m_skq, m_csq, m_diq, cs_armed;
  int          hi_run, lo_run, cslo_run, sess_rises, h_r0, h_r1;
  logic [10:0] hdr_cap, h_h0, h_h1;

  always @(negedge clk) begin
    if (rst) begin
      m_started = 0; m_rd = 0; m_armed = 0; m_wen = 0; m_cnt = 0; m_kind = 0;
      m_busy = 0; m_rb = 0; ee_do = 0; m_skq = 0; m_csq = 0; m_diq = 0;
      cs_armed = 0; hi_run = 0; lo_run = 0; cslo_run = 0; sess_rises = 0;
      h_r0 = 0; h_r1 = 0; hdr_cap = 0; h_h0 = 0; h_h1 = 0;
    end else begin
      if (ee_sk && !ee_cs) viol++;
      if (ee_sk && m_skq && ee_di !== m_diq) viol++;
      if (ee_sk) hi_run++;
      if (!ee_sk && m_skq) begin
        if (hi_run != TH) viol++;
        hi_run = 0;
      end
      if (ee_cs && !ee_sk) lo_run++;
      if (!ee_cs) cslo_run = m_csq ? 1 : cslo_run + 1;
      if (ee_cs && !m_csq) begin
        if (cs_armed && cslo_run < TG) viol++;
      end
      if (m_busy > 0 && !m_stuck) m_busy--;

      if (!ee_cs && m_csq) begin
        cs_armed = 1;
        h_r1 = h_r0; h_r0 = sess_rises; h_h1 = h_h0; h_h0 = hdr_cap;
        sess_rises = 0; hdr_cap = 0; lo_run = 0;
        if (m_armed && m_wen) begin
          case (m_kind)
            1: mem[m_a] = m_dat;
            2: mem[m_a] = 16'hFFFF;
            3: for (int i = 0; i < 128; i++) mem[i] = m_dat;
            4: for (int i = 0; i < 128; i++) mem[i] = 16'hFFFF;
            default: ;
          endcase
          m_busy = BUSYC;
        end
        m_started = 0; m_rd = 0; m_armed = 0; m_kind = 0; m_rb = 0;
      end

      if (ee_sk && !m_skq && ee_cs) begin
        if (lo_run < TL) viol++;
        lo_run = 0;
        sess_rises++;
        if (sess_rises <= 11) hdr_cap = {hdr_cap[9:0], ee_di};
        if (!m_started) begin
          if (ee_di) begin m_started = 1; m_cnt = 0; m_hdr = 0; m_kind = 0; end
        end else begin
          m_cnt++;
          if (m_rd && m_cnt >= 11) begin
            ee_do = mem[m_ra][15 - m_rb];
            m_rb++;
            if (m_rb == 16) begin m_rb = 0; m_ra = m_ra + 7'd1; end
          end
          if (m_cnt <= 10) m_hdr = {m_hdr[8:0], ee_di};
          if (m_cnt == 10) begin
            case (m_hdr[9:8])
              2'b10: begin m_rd = 1; m_ra = m_hdr[6:0]; m_rb = 0; ee_do = 0; end
              2'b01: begin m_kind = 1; m_a = m_hdr[6:0]; end
              2'b11: begin m_kind = 2; m_a = m_hdr[6:0]; m_armed = 1; end
              default: case (m_hdr[7:6])
                2'b11: m_wen = 1;
                2'b00: m_wen = 0;
                2'b01: m_kind = 3;
                default: begin m_kind = 4; m_armed = 1; end
              endcase
            endcase
          end
          if (m_cnt >= 11 && m_cnt <= 26 && (m_kind == 1 || m_kind == 3)) begin
            m_dat = {m_dat[14:0], ee_di};
            if (m_cnt == 26) m_armed = 1;
          end
        end
      end

      if (!m_rd)
        ee_do = (ee_cs && !m_started) ? (m_busy == 0 && !m_stuck) : 1'b0;

      if (rd_valid) begin
        if (rd_n < 8) rd_buf[rd_n] = rd_data;
        rd_n++;
      end
      if (done) done_n++;
      m_skq = ee_sk; m_csq = ee_cs; m_diq = ee_di;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] op, input logic [6:0] a,
                         input logic [15:0] d, input logic [7:0] n);
    int t0, t;
    @(negedge clk);
    while (busy) @(negedge clk);
    rd_n = 0;
    t0 = done_n;
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d; req_count = n;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (done_n == t0 && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 reset outputs", {25'd0, ee_cs, ee_sk, ee_di, busy, done, rd_valid, err_timeout}, 32'd0);
  endtask

  task automatic t_enable;
    run_req(OP_WEN, 7'd0, 16'd0, 8'd0);
    chk("R2 write-enable header", 32'(h_h0), 32'h4C0);
    chk("R4 write-enable clocks", h_r0, 11);
    chk("R2 model enabled", 32'(m_wen), 1);
  endtask

  task automatic t_write_read;
    run_req(OP_WRITE, 7'd5, 16'hA5C3, 8'd0);
    chk("R2 write header", 32'(h_h1), 32'h505);
    chk("R4 write clocks", h_r1, 27);
    chk("R7 no clocks while polling", h_r0, 0);
    chk("R8 no timeout on ready", 32'(err_timeout), 0);
    run_req(OP_READ, 7'd5, 16'd0, 8'd1);
    chk("R2 read header", 32'(h_h0), 32'h605);
    chk("R5 read clocks", h_r0, 27);
    chk("R5 word count", rd_n, 1);
    chk("R5 read data", 32'(rd_buf[0]), 32'hA5C3);
  endtask

  task automatic t_burst;
    run_req(OP_WRITE, 7'd126, 16'h1111, 8'd0);
    run_req(OP_WRITE, 7'd127, 16'h2222, 8'd0);
    run_req(OP_WRITE, 7'd0,   16'h3333, 8'd0);
    run_req(OP_READ,  7'd126, 16'd0,    8'd3);
    chk("R5 burst clocks", h_r0, 59);
    chk("R5 burst count", rd_n, 3);
    chk("R5 burst word0", 32'(rd_buf[0]), 32'h1111);
    chk("R5 burst word1", 32'(rd_buf[1]), 32'h2222);
    chk("R5 burst word2 wrapped", 32'(rd_buf[2]), 32'h3333);
    run_req(OP_READ, 7'd0, 16'd0, 8'd0);
    chk("R5 count zero reads one", rd_n, 1);
    chk("R5 count zero data", 32'(rd_buf[0]), 32'h3333);
  endtask

  task automatic t_disabled;
    run_req(OP_WDIS, 7'd0, 16'd0, 8'd0);
    chk("R2 write-disable header", 32'(h_h0), 32'h400);
    run_req(OP_WRITE, 7'd5, 16'hBEEF, 8'd0);
    run_req(OP_READ, 7'd5, 16'd0, 8'd1);
    chk("R2 disabled write kept data", 32'(rd_buf[0]), 32'hA5C3);
    run_req(OP_WEN, 7'd0, 16'd0, 8'd0);
  endtask

  task automatic t_refuse;
    int t0, t;
    bit saw_busy;
    @(negedge clk);
    while (busy) @(negedge clk);
    rd_n = 0; t0 = done_n;
    req_valid = 1; req_op = OP_READ; req_addr = 7'd126; req_count = 8'd4;
    @(negedge clk);
    req_valid = 0;
    repeat (50) @(negedge clk);
    req_valid = 1; req_op = OP_WRITE; req_addr = 7'd1; req_wdata = 16'h0;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (done_n == t0 && t < 20000) begin @(negedge clk); t++; end
    repeat (40) @(negedge clk);
    chk("R1 one transaction while busy", done_n - t0, 1);
    chk("R1 burst not disturbed", rd_n, 4);
    chk("R1 fourth word", 32'(rd_buf[3]), 32'h0101);
    chk("R1 no extra frame", h_r0, 75);
    t0 = done_n; saw_busy = 0;
    req_valid = 1; req_op = OP_NONE;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 20; i++) begin
      if (busy || ee_cs) saw_busy = 1;
      @(negedge clk);
    end
    chk("R1 opcode 7 ignored", {31'd0, saw_busy}, 0);
    chk("R1 opcode 7 no done", done_n - t0, 0);
  endtask

  task automatic t_bulk;
    run_req(OP_WALL, 7'd0, 16'h5A5A, 8'd0);
    chk("R2 write-all header", 32'(h_h1), 32'h440);
    chk("R4 write-all clocks", h_r1, 27);
    run_req(OP_READ, 7'd77, 16'd0, 8'd2);
    chk("R4 write-all word a", 32'(rd_buf[0]), 32'h5A5A);
    chk("R4 write-all word b", 32'(rd_buf[1]), 32'h5A5A);
    run_req(OP_ERASE, 7'd3, 16'd0, 8'd0);
    chk("R4 erase clocks", h_r1, 11);
    run_req(OP_READ, 7'd3, 16'd0, 8'd2);
    chk("R2 erase target", 32'(rd_buf[0]), 32'hFFFF);
    chk("R2 erase neighbour", 32'(rd_buf[1]), 32'h5A5A);
    run_req(OP_EALL, 7'd0, 16'd0, 8'd0);
    chk("R2 erase-all header", 32'(h_h1), 32'h480);
    run_req(OP_READ, 7'd10, 16'd0, 8'd1);
    chk("R2 erase-all data", 32'(rd_buf[0]), 32'hFFFF);
  endtask

  task automatic t_timeout;
    int t0;
    m_stuck = 1;
    t0 = done_n;
    run_req(OP_WRITE, 7'd9, 16'h0F0F, 8'd0);
    chk("R8 timeout flag", 32'(err_timeout), 1);
    chk("R8 done after timeout", done_n - t0, 1);
    chk("R8 cs released", 32'(ee_cs), 0);
    m_stuck = 0;
    run_req(OP_WEN, 7'd0, 16'd0, 8'd0);
    chk("R8 flag cleared by next request", 32'(err_timeout), 0);
  endtask

  initial begin
    rst = 1; req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0; req_count = 0;
    for (int i = 0; i < 128; i++) mem[i] = 16'h0100 + 16'(i);
    repeat (4) @(negedge clk);
    t_reset;
    rst = 0;
    @(negedge clk);
    t_reset;
    t_enable;
    t_write_read;
    t_burst;
    t_disabled;
    t_refuse;
    t_bulk;
    t_timeout;
    chk("R3 R6 line timing violations", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule